// File: doc/BRIEF.md
# Cascadable Configuration Stream Reader

This block is the read side of a configuration store that feeds a bitstream, one byte per clock, to a target device. The store holds four bitstream regions, and a two-bit revision picks one of them. The revision is captured when the shared program line returns high. It comes from an external select input when external selection is enabled, and otherwise from a fixed internal setting. A configuration command makes the block pull the open-drain program line low for a timed pulse. This resets the target and starts a fresh read of the selected region.

Several readers can be chained. Each reader's cascade-enable output drives the chip-enable input of the next reader. When a reader has delivered the last word of its region, it stops driving the shared data bus and enables its successor in the same cycle. The successor then supplies its own first word at once. A low level on output-enable/reset, or a high level on chip-enable, returns the address of every reader to the start of its region.

Top module: `cfg_stream_reader`

## Requirements
- R1: On the clock edge that consumes the last word of the region, `cascadeEnN` goes low and `dataEn` goes low together. While `cascadeEnN` is low, `dataEn` stays low. `cascadeEnN` is low only while the reader is finished and `chipEnN` is low.
- R2: `dataEn` is high in the same cycle, with no clock edge needed, whenever `chipEnN` is low, `oeRstN` is high and the reader is not finished. `dataEn` is low in every other case.
- R3: At any clock edge where `oeRstN` is low or `chipEnN` is high, the word offset returns to zero and the finished state is cleared.
- R4: A `cfgCmd` level seen high at an edge while no pulse is running sets `progDriveLow` high for exactly PULSE_CYC cycles. PULSE_CYC is round(CLK_KHZ*400/1e6), which gives 40 cycles (400 ns) at 100 MHz. A `cfgCmd` that arrives while a pulse is running is ignored.
- R5: The revision is latched at the first edge where `progLineIn` is seen high after being seen low. The value is `extRev` when `extSelEn` is high, and INT_REV otherwise. After reset the revision is INT_REV.
- R6: While `progLineIn` is low, and at the edge where the rise is detected, the offset is held at zero. Reading therefore starts at word 0 of the newly latched revision.
- R7: Revision r occupies addresses r*SPAN up to r*SPAN+len(r)-1. len(r) is byte r of REGION_WORDS (byte 0 is the least significant). The word stored at address a is (a*MIX + SALT) mod 2^DATA_W. `dataOut` shows the word at the current revision and offset.
- R8: At each edge where `chipEnN` is low, `oeRstN` is high, `progLineIn` is high, no rise is detected and the reader is not finished, the offset advances by one. When the offset is already at the last word, the reader becomes finished instead.
- R9: Unless a pulse from R4 is running, `progDriveLow` is low (the line is released). It is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipEnN | input | 1 | Chip enable, active low (upstream cascade output in a chain) |
| oeRstN | input | 1 | Output enable when high, address reset when low |
| cfgCmd | input | 1 | Configuration command request |
| extSelEn | input | 1 | Take the revision from `extRev` when high |
| extRev | input | REV_W | External revision select |
| progLineIn | input | 1 | Sensed level of the shared open-drain program line |
| progDriveLow | output | 1 | Pulls the program line low when high |
| cascadeEnN | output | 1 | Enables the next reader in the chain, active low |
| dataEn | output | 1 | Tri-state enable for the data byte |
| dataOut | output | DATA_W | Current configuration word |

## Verification
The bench builds two readers with the default 100 MHz setting, so the program pulse is 40 cycles. Both use SPAN 16 and region lengths of 5, 3, 6 and 4 words, and they differ only in SALT. These short regions make it practical to run complete chain handoffs for several revisions, and the distinct salts show which reader is driving the bus. With a 40-cycle pulse there is room to issue a second command in the middle of a pulse and to check the held offset, and then to confirm the exact pulse length and the revision captured on the rising edge.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
  typedef struct packed {
    logic clearAddr;
    logic advance;
    logic latchRev;
  } rdStrobe_t;
endpackage

// File: rtl/cfgrd_control.sv
module cfgrd_control
  import cfgrd_pkg::*;
#(
  parameter int PULSE_CYC = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipEnN,
  input  logic       oeRstN,
  input  logic       cfgCmd,
  input  logic       progLineIn,
  input  logic       lastWord,
  output rdStrobe_t  strobe,
  output logic       finished,
  output logic       progDriveLow
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] pulseCnt;
  logic             progPrev;
  logic             progRise;
  logic             clearCond;
  logic             active;

  always_comb begin
    progRise  = progLineIn & ~progPrev;
    clearCond = ~oeRstN | chipEnN | ~progLineIn;
    active    = ~chipEnN & oeRstN & progLineIn & ~progRise & ~finished;
    strobe.clearAddr = clearCond;
    strobe.advance   = active & ~lastWord;
    strobe.latchRev  = progRise;
  end

  assign progDriveLow = (pulseCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
      progPrev <= 1'b1;
      finished <= 1'b0;
    end else begin
      progPrev <= progLineIn;
      if (cfgCmd && pulseCnt == '0)
        pulseCnt <= CNT_W'(PULSE_CYC);
      else if (pulseCnt != '0)
        pulseCnt <= pulseCnt - 1'b1;
      if (clearCond)
        finished <= 1'b0;
      else if (active && lastWord)
        finished <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgrd_datapath.sv
module cfgrd_datapath
  import cfgrd_pkg::*;
#(
  parameter int REV_W  = 2,
  parameter int SPAN   = 16,
  parameter int DATA_W = 8,
  parameter int MIX    = 37,
  parameter int SALT   = 17,
  parameter int INT_REV = 1,
  parameter logic [8*(1<<REV_W)-1:0] REGION_WORDS = 32'h04_06_03_05
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strobe,
  input  logic              extSelEn,
  input  logic [REV_W-1:0]  extRev,
  output logic              lastWord,
  output logic [DATA_W-1:0] dataWord
);
  localparam int REGIONS = 1 << REV_W;
  localparam int DEPTH   = REGIONS * SPAN;
  localparam int OFF_W   = $clog2(SPAN);
  localparam int ADDR_W  = $clog2(DEPTH);

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [REV_W-1:0]  revReg;
  logic [OFF_W-1:0]  offset;
  logic [7:0]        regionLen;
  logic [ADDR_W-1:0] addr;

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign memArr[a] = DATA_W'(a * MIX + SALT);
  end

  always_comb begin
    regionLen = REGION_WORDS[8*revReg +: 8];
    lastWord  = (8'(offset) == regionLen - 8'd1);
    addr      = {revReg, offset};
    dataWord  = memArr[addr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      revReg <= REV_W'(INT_REV);
      offset <= '0;
    end else begin
      if (strobe.latchRev)
        revReg <= extSelEn ? extRev : REV_W'(INT_REV);
      if (strobe.clearAddr)
        offset <= '0;
      else if (strobe.advance)
        offset <= offset + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
  import cfgrd_pkg::*;
#(
  parameter int CLK_KHZ = 100_000,
  parameter int REV_W   = 2,
  parameter int SPAN    = 16,
  parameter int DATA_W  = 8,
  parameter int MIX     = 37,
  parameter int SALT    = 17,
  parameter int INT_REV = 1,
  parameter logic [8*(1<<REV_W)-1:0] REGION_WORDS = 32'h04_06_03_05
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              oeRstN,
  input  logic              cfgCmd,
  input  logic              extSelEn,
  input  logic [REV_W-1:0]  extRev,
  input  logic              progLineIn,
  output logic              progDriveLow,
  output logic              cascadeEnN,
  output logic              dataEn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int PULSE_CYC = (CLK_KHZ * 400 + 500_000) / 1_000_000;

  rdStrobe_t strobe;
  logic      lastWord;
  logic      finished;

  cfgrd_control #(.PULSE_CYC(PULSE_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .oeRstN(oeRstN),
    .cfgCmd(cfgCmd), .progLineIn(progLineIn), .lastWord(lastWord),
    .strobe(strobe), .finished(finished), .progDriveLow(progDriveLow)
  );

  cfgrd_datapath #(
    .REV_W(REV_W), .SPAN(SPAN), .DATA_W(DATA_W), .MIX(MIX), .SALT(SALT),
    .INT_REV(INT_REV), .REGION_WORDS(REGION_WORDS)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .extSelEn(extSelEn),
    .extRev(extRev), .lastWord(lastWord), .dataWord(dataOut)
  );

  assign dataEn     = ~chipEnN & oeRstN & ~finished;
  assign cascadeEnN = ~(finished & ~chipEnN);
endmodule

// File: rtl/cfg_stream_reader_chk.sv
module cfg_stream_reader_chk #(
  parameter int CLK_KHZ = 100_000
) (
  input logic clk,
  input logic rstN,
  input logic chipEnN,
  input logic oeRstN,
  input logic cfgCmd,
  input logic progDriveLow,
  input logic cascadeEnN,
  input logic dataEn
);
  localparam int PULSE_CYC = (CLK_KHZ * 400 + 500_000) / 1_000_000;
  localparam int CNT_W = $clog2(PULSE_CYC + 2);

  logic [CNT_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (progDriveLow) lowCnt <= lowCnt + 1'b1;
    else lowCnt <= '0;
  end

  // R1
  handoff_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cascadeEnN |-> !dataEn);
  // R2
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    chipEnN |-> !dataEn);
  // R3
  oe_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oeRstN |=> cascadeEnN);
  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progDriveLow) |-> $past(cfgCmd));
  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progDriveLow) |-> (lowCnt == CNT_W'(PULSE_CYC)));
endmodule

bind cfg_stream_reader cfg_stream_reader_chk #(.CLK_KHZ(CLK_KHZ)) uChk (
  .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .oeRstN(oeRstN),
  .cfgCmd(cfgCmd), .progDriveLow(progDriveLow), .cascadeEnN(cascadeEnN),
  .dataEn(dataEn)
);

// File: tb/sim_cfg_stream_reader.sv
module sim_cfg_stream_reader;
  localparam int PULSE = 40;
  localparam int SPAN = 16;
  localparam int MIX = 37;
  localparam int SALT0 = 17;
  localparam int SALT1 = 200;
  localparam int INTREV = 1;
  localparam logic [31:0] RW = 32'h04_06_03_05;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, ceN = 1'b1, oeRstN = 1'b1, cmd = 1'b0;
  logic extSelEn = 1'b0, holdLow = 1'b0;
  logic [1:0] extRev = 2'd0;
  logic drv0, drv1, cas0, cas1, en0, en1;
  logic [7:0] d0, d1;
  wire line = ~(drv0 | drv1 | holdLow);

  int checks = 0, errors = 0;
  bit running = 1'b0;

  cfg_stream_reader #(.SALT(SALT0)) u0 (
    .clk(clk), .rstN(rstN), .chipEnN(ceN), .oeRstN(oeRstN), .cfgCmd(cmd),
    .extSelEn(extSelEn), .extRev(extRev), .progLineIn(line),
    .progDriveLow(drv0), .cascadeEnN(cas0), .dataEn(en0), .dataOut(d0));
  cfg_stream_reader #(.SALT(SALT1)) u1 (
    .clk(clk), .rstN(rstN), .chipEnN(cas0), .oeRstN(oeRstN), .cfgCmd(1'b0),
    .extSelEn(extSelEn), .extRev(extRev), .progLineIn(line),
    .progDriveLow(drv1), .cascadeEnN(cas1), .dataEn(en1), .dataOut(d1));

  function automatic int lenOf(int r);
    return int'((RW >> (8 * r)) & 32'hff);
  endfunction
  function automatic int wordOf(int salt, int r, int off);
    return ((r * SPAN + off) * MIX + salt) & 255;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference state
  int mPulse, mOff0, mOff1, mRev;
  bit mDone0, mDone1, mPrev;
  bit ln, rise, ce1N, clr0, clr1, act0, act1, last0, last1;

  always @(posedge clk) begin
    if (!rstN) begin
      mPulse = 0; mOff0 = 0; mOff1 = 0; mRev = INTREV;
      mDone0 = 0; mDone1 = 0; mPrev = 1;
    end else begin
      ln    = (mPulse == 0) && !holdLow;
      rise  = ln && !mPrev;
      ce1N  = !(mDone0 && !ceN);
      clr0  = !oeRstN || ceN || !ln;
      clr1  = !oeRstN || ce1N || !ln;
      act0  = !ceN && oeRstN && ln && !rise && !mDone0;
      act1  = !ce1N && oeRstN && ln && !rise && !mDone1;
      last0 = (mOff0 == lenOf(mRev) - 1);
      last1 = (mOff1 == lenOf(mRev) - 1);
      if (clr0) begin mOff0 = 0; mDone0 = 0; end
      else if (act0) begin if (last0) mDone0 = 1; else mOff0++; end
      if (clr1) begin mOff1 = 0; mDone1 = 0; end
      else if (act1) begin if (last1) mDone1 = 1; else mOff1++; end
      if (rise) mRev = extSelEn ? int'(extRev) : INTREV;
      if (cmd && mPulse == 0) mPulse = PULSE;
      else if (mPulse > 0) mPulse--;
      mPrev = ln;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && running) begin
      bit eLine, eEn0, eEn1, eCas0, eCas1;
      eLine = (mPulse == 0) && !holdLow;
      eEn0  = !ceN && oeRstN && !mDone0;
      eCas0 = !(mDone0 && !ceN);
      eEn1  = !eCas0 && oeRstN && !mDone1;
      eCas1 = !(mDone1 && !eCas0);
      check(line == eLine, "R4 program line", line, eLine);
      check(en0 == eEn0, "R2 enable u0", en0, eEn0);
      check(en1 == eEn1, "R2 enable u1", en1, eEn1);
      check(cas0 == eCas0, "R1 cascade u0", cas0, eCas0);
      check(cas1 == eCas1, "R1 cascade u1", cas1, eCas1);
      check(!(en0 && en1), "R1 single driver", en0 + en1, 1);
      if (eEn0) check(d0 == wordOf(SALT0, mRev, mOff0), "R8 data u0", d0, wordOf(SALT0, mRev, mOff0));
      if (eEn1) check(d1 == wordOf(SALT1, mRev, mOff1), "R7 data u1", d1, wordOf(SALT1, mRev, mOff1));
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic holdPulse(int rev);
    @(posedge clk); #1 holdLow = 1'b1;
    repeat (5) @(posedge clk);
    #1 holdLow = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(en0 && d0 == wordOf(SALT0, rev, 0), "R5 revision after line rise", d0, wordOf(SALT0, rev, 0));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lowCnt;
    cycles(3);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);
    check(line == 1'b1 && !drv0, "R9 line released after reset", line, 1);
    check(!en0 && cas0, "R2 idle after reset", en0, 0);
    cycles(3);

    // full chain stream of the internal revision, no idle bus cycle
    ceN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(en0 || en1, "R1 no gap during handoff", en0 + en1, 1);
    end
    @(negedge clk);
    check(!cas1 && !en0 && !en1, "R1 chain finished, bus released", cas1, 0);
    cycles(2);

    // output-enable low resets both readers together
    oeRstN = 1'b0; cycles(1); oeRstN = 1'b1;
    @(negedge clk);
    check(en0 && cas0 && d0 == wordOf(SALT0, INTREV, 0), "R3 restart after oe low", d0, wordOf(SALT0, INTREV, 0));
    cycles(2);
    ceN = 1'b1; cycles(1); ceN = 1'b0;
    @(negedge clk);
    check(d0 == wordOf(SALT0, INTREV, 0), "R3 restart after chip-enable high", d0, wordOf(SALT0, INTREV, 0));
    cycles(2);

    // configuration command with external revision 2, repeated mid-pulse
    extSelEn = 1'b1; extRev = 2'd2;
    cmd = 1'b1; cycles(1); cmd = 1'b0;
    lowCnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (line) break;
      lowCnt++;
      if (lowCnt == 5) check(d0 == wordOf(SALT0, INTREV, 0), "R6 offset held while line low", d0, wordOf(SALT0, INTREV, 0));
      if (lowCnt == 10) cmd = 1'b1;
      if (lowCnt == 11) cmd = 1'b0;
    end
    check(lowCnt == PULSE, "R4 pulse length", lowCnt, PULSE);
    @(posedge clk);
    @(negedge clk);
    check(en0 && d0 == wordOf(SALT0, 2, 0), "R5 external revision latched", d0, wordOf(SALT0, 2, 0));
    @(negedge clk);
    check(d0 == wordOf(SALT0, 2, 1), "R8 advance after latch", d0, wordOf(SALT0, 2, 1));
    cycles(20);
    check(!drv0 && line, "R9 line released without command", line, 1);

    // internal revision when external selection is off
    extSelEn = 1'b0; extRev = 2'd3;
    holdPulse(INTREV);
    cycles(15);

    // external revision 3 latched from an externally pulled line
    extSelEn = 1'b1;
    holdPulse(3);
    cycles(12);
    @(negedge clk);
    check(!cas1, "R1 revision 3 chain finished", cas1, 0);
    oeRstN = 1'b0; cycles(1);
    @(negedge clk);
    check(cas0 && cas1, "R3 both counters reset together", cas0 + cas1, 2);
    oeRstN = 1'b1;
    cycles(4);

    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule